// File: doc/BRIEF.md
# Hash Engine Command and Status Front-End

This block is the register front-end of a hash accelerator. Software uses a 32-bit little-endian valid/ready bus to program a source address, a destination address and a source length. Writing the hash command register both stores the command and, when its algorithm fields decode to a supported digest and no job is running, sends a one-cycle start pulse to the hash datapath. The pulse carries the decoded algorithm code and the scatter-gather flag. The datapath sits behind a start/done handshake. The digest arithmetic, the memory transfers and the keyed and chained modes live elsewhere.

When the datapath reports done, the block sets a completion bit in its status register whether or not interrupts are enabled. It raises a registered level interrupt only if the command that started the job had its interrupt-enable bit set. Software writes one to the completion bit to clear both the bit and the line. A crypt command word is held for software and has no effect on hashing.

Top module: `hash_ctl_front`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `job_start` is 0. An asynchronous reset during a job clears the interrupt at once.
- R2: Writes are masked per register. Source keeps bits under 0x7FFFFFFF, destination under 0x7FFFFFF8, length under 0x0FFFFFFF and hash command under 0x00147FFF. The crypt command is kept whole. A read returns the stored value on `rsp_rdata` with `rsp_valid` high one cycle after the read is accepted.
- R3: The mapped byte offsets are 0x10 crypt command, 0x1C status, 0x20 source, 0x24 destination, 0x2C length and 0x30 hash command. Any other offset reads 0 and ignores writes. `req_ready` is always 1.
- R4: The command family field (bits 6:4) and variant field (bits 12:10) decode as {variant,family}: 000/000 MD5 code 0, 000/010 SHA-1 code 1, 000/100 SHA-224 code 2, 000/101 SHA-256 code 3, 000/110 SHA-512 code 4, 001/110 SHA-384 code 5, 010/110 SHA-512/256 code 6. The code is driven on `job_alg`.
- R5: Any other combination of the two fields stores the command but starts no job.
- R6: A valid command write accepted at one clock edge makes `job_start` high for exactly the following cycle. `job_sg` then equals command bit 18.
- R7: Status bit 0 (busy) is 1 from the start pulse until `job_done` is sampled. A command written while busy is stored but starts nothing.
- R8: A sampled `job_done` while busy sets status bit 9 regardless of interrupt enable. A `job_done` while idle has no effect.
- R9: `irq` rises in the cycle after the completing `job_done` only if bit 9 of the starting command was 1. While `irq` is 1, status bit 9 is 1.
- R10: Writing status with bit 9 = 1 clears status bit 9, and `irq` is 0 from the next cycle. Writing 0 there changes nothing. If a completion arrives in the same cycle as a clear, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| job_start | output | 1 | One-cycle start pulse to the datapath |
| job_alg | output | 3 | Decoded algorithm code |
| job_sg | output | 1 | Scatter-gather mode for the job |
| job_src | output | 32 | Source address register |
| job_dst | output | 32 | Destination address register |
| job_len | output | 32 | Source length register |
| job_done | input | 1 | Datapath completion pulse |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that `job_done` is a single-cycle pulse and that a bus request is held for only the one cycle in which it is accepted. The stimulus drives every request and every done pulse for exactly one clock, on the falling edge. It sends `job_done` only after a start has been seen, except in the case where a done pulse is sent on purpose while idle. The one check of a clear and a completion in the same cycle drives both on a single edge, so the set-wins rule is exercised without breaking these assumptions.

// File: rtl/hash_ctl_pkg.sv
package hash_ctl_pkg;
  typedef enum logic [2:0] {
    ALG_MD5        = 3'd0,
    ALG_SHA1       = 3'd1,
    ALG_SHA224     = 3'd2,
    ALG_SHA256     = 3'd3,
    ALG_SHA512     = 3'd4,
    ALG_SHA384     = 3'd5,
    ALG_SHA512_256 = 3'd6
  } hash_alg_e;

  localparam int unsigned OFF_CRYPT  = 'h10;
  localparam int unsigned OFF_STATUS = 'h1C;
  localparam int unsigned OFF_SRC    = 'h20;
  localparam int unsigned OFF_DST    = 'h24;
  localparam int unsigned OFF_LEN    = 'h2C;
  localparam int unsigned OFF_CMD    = 'h30;

  localparam int unsigned CMD_IRQEN_BIT  = 9;
  localparam int unsigned CMD_SG_BIT     = 18;
  localparam int unsigned STAT_DONE_BIT  = 9;
  localparam int unsigned STAT_BUSY_BIT  = 0;
endpackage

// File: rtl/hash_alg_decode.sv
module hash_alg_decode
  import hash_ctl_pkg::*;
(
  input  logic [2:0] family_i,
  input  logic [2:0] variant_i,
  output logic       ok_o,
  output hash_alg_e  alg_o
);
  always_comb begin
    ok_o  = 1'b1;
    alg_o = ALG_MD5;
    case ({variant_i, family_i})
      6'b000_000: alg_o = ALG_MD5;
      6'b000_010: alg_o = ALG_SHA1;
      6'b000_100: alg_o = ALG_SHA224;
      6'b000_101: alg_o = ALG_SHA256;
      6'b000_110: alg_o = ALG_SHA512;
      6'b001_110: alg_o = ALG_SHA384;
      6'b010_110: alg_o = ALG_SHA512_256;
      default:    ok_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/hash_reg_file.sv
module hash_reg_file #(
  parameter int unsigned DATA_W   = 32,
  parameter logic [DATA_W-1:0] SRC_MASK = 32'h7FFF_FFFF,
  parameter logic [DATA_W-1:0] DST_MASK = 32'h7FFF_FFF8,
  parameter logic [DATA_W-1:0] LEN_MASK = 32'h0FFF_FFFF,
  parameter logic [DATA_W-1:0] CMD_MASK = 32'h0014_7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_src_i,
  input  logic              we_dst_i,
  input  logic              we_len_i,
  input  logic              we_cmd_i,
  input  logic              we_crypt_i,
  output logic [DATA_W-1:0] src_o,
  output logic [DATA_W-1:0] dst_o,
  output logic [DATA_W-1:0] len_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic [DATA_W-1:0] crypt_o
);
  logic [DATA_W-1:0] src_d, dst_d, len_d, cmd_d, crypt_d;

  always_comb begin
    src_d   = we_src_i   ? (wdata_i & SRC_MASK) : src_o;
    dst_d   = we_dst_i   ? (wdata_i & DST_MASK) : dst_o;
    len_d   = we_len_i   ? (wdata_i & LEN_MASK) : len_o;
    cmd_d   = we_cmd_i   ? (wdata_i & CMD_MASK) : cmd_o;
    crypt_d = we_crypt_i ? wdata_i              : crypt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_o   <= '0;
      dst_o   <= '0;
      len_o   <= '0;
      cmd_o   <= '0;
      crypt_o <= '0;
    end else begin
      src_o   <= src_d;
      dst_o   <= dst_d;
      len_o   <= len_d;
      cmd_o   <= cmd_d;
      crypt_o <= crypt_d;
    end
  end

  AST_DST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    dst_o[2:0] == 3'b000); // R2
endmodule

// File: rtl/hash_job_ctrl.sv
module hash_job_ctrl
  import hash_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_wr_i,
  input  logic      alg_ok_i,
  input  hash_alg_e alg_i,
  input  logic      sg_i,
  input  logic      irq_en_i,
  input  logic      done_i,
  input  logic      clr_i,
  output logic      start_o,
  output hash_alg_e alg_o,
  output logic      sg_o,
  output logic      busy_o,
  output logic      done_flag_o,
  output logic      irq_o
);
  logic start_d, busy_d, flag_d, irq_d, irq_en_q, irq_en_d, finish;
  hash_alg_e alg_d;
  logic sg_d;

  always_comb begin
    finish   = done_i && busy_o;
    start_d  = cmd_wr_i && alg_ok_i && !busy_o;
    alg_d    = start_d ? alg_i : alg_o;
    sg_d     = start_d ? sg_i : sg_o;
    irq_en_d = start_d ? irq_en_i : irq_en_q;
    busy_d   = busy_o;
    if (start_d)     busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;
    flag_d = done_flag_o;
    if (finish)     flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
    irq_d = irq_o;
    if (finish && irq_en_q) irq_d = 1'b1;
    else if (clr_i)         irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o     <= 1'b0;
      alg_o       <= ALG_MD5;
      sg_o        <= 1'b0;
      irq_en_q    <= 1'b0;
      busy_o      <= 1'b0;
      done_flag_o <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      start_o     <= start_d;
      alg_o       <= alg_d;
      sg_o        <= sg_d;
      irq_en_q    <= irq_en_d;
      busy_o      <= busy_d;
      done_flag_o <= flag_d;
      irq_o       <= irq_d;
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o); // R6
  AST_BUSY_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cmd_wr_i) |=> !start_o); // R7
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !busy_o && !done_flag_o) |=> !done_flag_o); // R8
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done_flag_o); // R9
  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(done_i && busy_o)) |=> (!irq_o && !done_flag_o)); // R10
endmodule

// File: rtl/hash_ctl_front.sv
module hash_ctl_front
  import hash_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              job_start,
  output logic [2:0]        job_alg,
  output logic              job_sg,
  output logic [DATA_W-1:0] job_src,
  output logic [DATA_W-1:0] job_dst,
  output logic [DATA_W-1:0] job_len,
  input  logic              job_done,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CRYPT  = ADDR_W'(OFF_CRYPT);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_SRC    = ADDR_W'(OFF_SRC);
  localparam logic [ADDR_W-1:0] A_DST    = ADDR_W'(OFF_DST);
  localparam logic [ADDR_W-1:0] A_LEN    = ADDR_W'(OFF_LEN);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFF_CMD);

  logic wr, rd;
  logic [DATA_W-1:0] cmd_q, crypt_q, status_w, rdata_d;
  logic alg_ok, busy, done_flag, stat_clr;
  hash_alg_e alg_dec, alg_q;

  assign req_ready = 1'b1;
  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;
  assign stat_clr = wr && (req_addr == A_STATUS) && req_wdata[STAT_DONE_BIT];

  hash_reg_file #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdata_i    (req_wdata),
    .we_src_i   (wr && (req_addr == A_SRC)),
    .we_dst_i   (wr && (req_addr == A_DST)),
    .we_len_i   (wr && (req_addr == A_LEN)),
    .we_cmd_i   (wr && (req_addr == A_CMD)),
    .we_crypt_i (wr && (req_addr == A_CRYPT)),
    .src_o      (job_src),
    .dst_o      (job_dst),
    .len_o      (job_len),
    .cmd_o      (cmd_q),
    .crypt_o    (crypt_q)
  );

  hash_alg_decode u_dec (
    .family_i  (req_wdata[6:4]),
    .variant_i (req_wdata[12:10]),
    .ok_o      (alg_ok),
    .alg_o     (alg_dec)
  );

  hash_job_ctrl u_job (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr_i    (wr && (req_addr == A_CMD)),
    .alg_ok_i    (alg_ok),
    .alg_i       (alg_dec),
    .sg_i        (req_wdata[CMD_SG_BIT]),
    .irq_en_i    (req_wdata[CMD_IRQEN_BIT]),
    .done_i      (job_done),
    .clr_i       (stat_clr),
    .start_o     (job_start),
    .alg_o       (alg_q),
    .sg_o        (job_sg),
    .busy_o      (busy),
    .done_flag_o (done_flag),
    .irq_o       (irq)
  );

  assign job_alg = alg_q;

  always_comb begin
    status_w = '0;
    status_w[STAT_DONE_BIT] = done_flag;
    status_w[STAT_BUSY_BIT] = busy;
    case (req_addr)
      A_CRYPT:  rdata_d = crypt_q;
      A_STATUS: rdata_d = status_w;
      A_SRC:    rdata_d = job_src;
      A_DST:    rdata_d = job_dst;
      A_LEN:    rdata_d = job_len;
      A_CMD:    rdata_d = cmd_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rdata_d;
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write)); // R2
  AST_START_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |-> $past(wr && (req_addr == A_CMD))); // R6
endmodule

// File: tb/hash_ctl_front_test.sv
module hash_ctl_front_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, job_start, job_sg, irq;
  logic [31:0] rsp_rdata, job_src, job_dst, job_len;
  logic [2:0] job_alg;
  logic job_done = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic seen_start, seen_sg;
  logic [2:0] seen_alg;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  hash_ctl_front uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .job_start(job_start),
    .job_alg(job_alg), .job_sg(job_sg), .job_src(job_src), .job_dst(job_dst),
    .job_len(job_len), .job_done(job_done), .irq(irq)
  );

  // [95:80] addr, [79:48] wdata, [47:16] readback, [15:8] {sg,start}, [7:0] alg
  localparam int NV = 17;
  localparam logic [95:0] VEC [0:NV-1] = '{
    {16'h20, 32'hFFFFFFFF, 32'h7FFFFFFF, 8'h0, 8'h0},  // R2
    {16'h24, 32'hFFFFFFFF, 32'h7FFFFFF8, 8'h0, 8'h0},  // R2
    {16'h2C, 32'hFFFFFFFF, 32'h0FFFFFFF, 8'h0, 8'h0},  // R2
    {16'h10, 32'hDEADBEEF, 32'hDEADBEEF, 8'h0, 8'h0},  // R2 R3
    {16'h44, 32'h12345678, 32'h00000000, 8'h0, 8'h0},  // R3
    {16'h30, 32'h00000000, 32'h00000000, 8'h1, 8'h0},  // R4
    {16'h30, 32'h00000020, 32'h00000020, 8'h1, 8'h1},  // R4
    {16'h30, 32'h00000040, 32'h00000040, 8'h1, 8'h2},  // R4
    {16'h30, 32'h00000050, 32'h00000050, 8'h1, 8'h3},  // R4
    {16'h30, 32'h00000060, 32'h00000060, 8'h1, 8'h4},  // R4
    {16'h30, 32'h00000460, 32'h00000460, 8'h1, 8'h5},  // R4
    {16'h30, 32'h00000860, 32'h00000860, 8'h1, 8'h6},  // R4
    {16'h30, 32'h00000C60, 32'h00000C60, 8'h0, 8'h0},  // R5
    {16'h30, 32'h00000070, 32'h00000070, 8'h0, 8'h0},  // R5
    {16'h30, 32'h00000450, 32'h00000450, 8'h0, 8'h0},  // R5
    {16'h30, 32'h00040060, 32'h00040060, 8'h3, 8'h4},  // R6
    {16'h30, 32'hFFFFFFFF, 32'h00147FFF, 8'h0, 8'h0}   // R2 R5
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    seen_start = job_start; seen_alg = job_alg; seen_sg = job_sg;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R2 rsp_valid", 32'(rsp_valid), 32'h1);
    d = rsp_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); job_done = 1'b1;
    @(negedge clk); job_done = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(irq === 1'b0 && job_start === 1'b0, "R1 outputs", {30'b0, irq, job_start}, 32'h0);
    chk(req_ready === 1'b1, "R3 ready", 32'(req_ready), 32'h1);
    foreach (VEC[i]) begin
      if (i < 6) begin
        rd(VEC[i][95:84] == 0 ? VEC[i][91:80] : 12'h0, rv);
      end
    end
    rd(12'h1C, rv); chk(rv == 0, "R1 status", rv, 0);
    rd(12'h30, rv); chk(rv == 0, "R1 cmd", rv, 0);
    rd(12'h20, rv); chk(rv == 0, "R1 src", rv, 0);
    rd(12'h10, rv); chk(rv == 0, "R1 crypt", rv, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][91:80], VEC[i][79:48]);
      chk(seen_start === VEC[i][8], "R4/R5/R6 start", 32'(seen_start), 32'(VEC[i][8]));
      if (VEC[i][8]) begin
        chk(seen_alg === VEC[i][2:0], "R4 alg", 32'(seen_alg), 32'(VEC[i][2:0]));
        chk(seen_sg === VEC[i][9], "R6 sg", 32'(seen_sg), 32'(VEC[i][9]));
        @(negedge clk);
        chk(job_start === 1'b0, "R6 single pulse", 32'(job_start), 0);
        rd(12'h1C, rv); chk(rv[0] === 1'b1, "R7 busy", rv, 32'h1);
        pulse_done();
      end
      rd(VEC[i][91:80], rv);
      chk(rv === VEC[i][47:16], "R2/R3 readback", rv, VEC[i][47:16]);
    end

    // R10 clear, then R8 idle done ignored
    wr(12'h1C, 32'h200);
    rd(12'h1C, rv); chk(rv == 0, "R10 clear", rv, 0);
    pulse_done();
    rd(12'h1C, rv); chk(rv == 0, "R8 idle done", rv, 0);
    chk(irq === 1'b0, "R8 idle irq", 32'(irq), 0);

    // R7 command while busy
    wr(12'h30, 32'h50);
    chk(seen_start === 1'b1, "R7 first start", 32'(seen_start), 1);
    wr(12'h30, 32'h20);
    chk(seen_start === 1'b0, "R7 no restart", 32'(seen_start), 0);
    rd(12'h30, rv); chk(rv == 32'h20, "R7 stored", rv, 32'h20);
    pulse_done();
    rd(12'h1C, rv); chk(rv == 32'h200, "R8 status no irqen", rv, 32'h200);
    chk(irq === 1'b0, "R9 no irq when disabled", 32'(irq), 0);
    wr(12'h1C, 32'h200);

    // R9 irq enabled
    wr(12'h30, 32'h250);
    chk(irq === 1'b0, "R9 irq before done", 32'(irq), 0);
    pulse_done();
    chk(irq === 1'b1, "R9 irq after done", 32'(irq), 1);
    wr(12'h1C, 32'h0);
    chk(irq === 1'b1, "R10 zero write keeps irq", 32'(irq), 1);
    rd(12'h1C, rv); chk(rv == 32'h200, "R10 zero write keeps bit", rv, 32'h200);
    wr(12'h1C, 32'h200);
    chk(irq === 1'b0, "R10 irq cleared", 32'(irq), 0);
    rd(12'h1C, rv); chk(rv == 0, "R10 status cleared", rv, 0);

    // R10 clear and completion same cycle: set wins
    wr(12'h30, 32'h250);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h1C; req_wdata = 32'h200; job_done = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; job_done = 1'b0;
    chk(irq === 1'b1, "R10 set wins irq", 32'(irq), 1);
    rd(12'h1C, rv); chk(rv == 32'h200, "R10 set wins status", rv, 32'h200);

    // R1 reset during activity
    wr(12'h20, 32'h1234);
    @(negedge clk); rst_n = 1'b0; #1;
    chk(irq === 1'b0, "R1 async reset irq", 32'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    rd(12'h1C, rv); chk(rv == 0, "R1 status after reset", rv, 0);
    rd(12'h20, rv); chk(rv == 0, "R1 src after reset", rv, 0);

    summary();
  end
endmodule